// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Receiver

This block receives asynchronous serial characters for a multidrop network. Each character has one start bit, nine data bits sent least significant bit first, and a stop bit. The serial line is sampled on a clock enable that runs at sixteen times the bit rate. A received character gives an 8-bit data byte and a separate ninth bit. On a multidrop link the ninth bit tells an address character from a data character.

Software can arm an attention mode. While it is armed, the receiver drops data characters without any trace. The first address character is stored and flagged, and the hardware then disarms attention, so the data that follows is accepted too. Software re-arms attention if the addressed station is not this one. A diagnostic loopback feeds the local transmitter's serial output into the receiver in place of the pin.

The block also raises an edge pulse on the receive line that can serve as a wake-up event. On entry to a low-power state it clears its read-only status flags and keeps the received data.

Top module: `mdrop_rx`

## Requirements
- R1: A character is a low start bit, nine data bits least significant first, then a stop bit. Bits are taken at the middle of each bit time, counting `sampleTick` pulses at 16 per bit. Data bits 0 to 7 appear on `rxData` and data bit 8 appears on `rxBit9`.
- R2: An accepted character loads `rxData` and `rxBit9` and sets `bufFull`. A `bufRead` pulse clears `bufFull`. If a new character is accepted in the same cycle as `bufRead`, `bufFull` stays set.
- R3: While `attnArmed` is 1, a character whose ninth bit is 0 is discarded. `rxData`, `rxBit9`, `bufFull`, `frameErr` and `overrunErr` all stay unchanged.
- R4: A character whose ninth bit is 1 is always accepted. If attention was armed, the hardware clears `attnArmed` and later data characters are accepted. A `attnSet` pulse arms attention again, and it wins over the hardware clear in the same cycle.
- R5: An accepted character whose stop bit samples low sets `frameErr`.
- R6: A character accepted while `bufFull` is still 1 sets `overrunErr`, and the new character overwrites the buffer.
- R7: A `statusWr` pulse clears `frameErr` and `overrunErr` and leaves `rxData`, `rxBit9` and `bufFull` unchanged. An error raised in the same cycle wins over the clear.
- R8: When `charLenSel` is 2'b11, the receiver takes its input from `txLoopIn` and ignores `rxPin`. For every other value it takes `rxPin` and ignores `txLoopIn`.
- R9: With `wakeEn` at 1, `wakeEvt` pulses for one cycle on each falling edge of the selected line if `wakeFallSel` is 1, and on each rising edge if `wakeFallSel` is 0. With `wakeEn` at 0, `wakeEvt` stays 0.
- R10: A rising edge of `lowPower` clears `bufFull`, `frameErr` and `overrunErr` and aborts any character in progress. It leaves `rxData`, `rxBit9` and `attnArmed` unchanged.
- R11: If the line is high again at the middle of the start bit, the start bit is rejected and no character is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Enable at 16 times the bit rate |
| rxPin | input | 1 | Serial receive pin, idle high |
| txLoopIn | input | 1 | Local transmitter serial output, used in loopback |
| charLenSel | input | 2 | Character-length control; 2'b11 selects loopback |
| wakeEn | input | 1 | Enables the wake pulse |
| wakeFallSel | input | 1 | 1: wake on a falling edge, 0: wake on a rising edge |
| lowPower | input | 1 | Low-power state request; its rising edge clears the status flags |
| attnSet | input | 1 | Pulse that arms attention mode |
| bufRead | input | 1 | Pulse that marks the buffer as read |
| statusWr | input | 1 | Pulse for a write to the status register; clears the error flags |
| rxData | output | 8 | Received data byte |
| rxBit9 | output | 1 | Received ninth bit |
| bufFull | output | 1 | Receive buffer holds an unread character |
| frameErr | output | 1 | Framing error flag |
| overrunErr | output | 1 | Overrun error flag |
| attnArmed | output | 1 | Attention mode is armed |
| wakeEvt | output | 1 | One-cycle wake pulse |

## Verification
The buffer, `bufFull`, the error flags and `attnArmed` change one clock after the tick that samples the middle of the stop bit. That tick comes about 18 to 20 clocks into the stop bit once the two synchronizer stages are counted. The bench keeps the line idle for 48 clocks after every character before it looks at these outputs. `wakeEvt` follows a line edge on the third clock edge, so the bench counts pulses over an 8-clock window after each edge and compares the total. The low-power clear comes one clock after `lowPower` rises. Every check samples on a falling clock edge.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic frameDone;
    logic stopBad;
  } rxStrobe_t;
endpackage

// File: rtl/mdrop_rx_front.sv
module mdrop_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPin,
  input  logic       txLoopIn,
  input  logic [1:0] charLenSel,
  input  logic       wakeEn,
  input  logic       wakeFallSel,
  input  logic       lowPower,
  output logic       lineS,
  output logic       wakeEvt,
  output logic       lpEnter
);
  logic                   loopEn;
  logic                   lineIn;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineD;
  logic                   lpQ;

  assign loopEn = &charLenSel;
  assign lineIn = loopEn ? txLoopIn : rxPin;
  assign lineS  = syncQ[SYNC_STAGES-1];
  assign lpEnter = lowPower & ~lpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      lineD   <= 1'b1;
      wakeEvt <= 1'b0;
      lpQ     <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineIn};
      lineD   <= lineS;
      wakeEvt <= wakeEn & (wakeFallSel ? (lineD & ~lineS) : (~lineD & lineS));
      lpQ     <= lowPower;
    end
  end

  AST_WAKE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !wakeEn |=> !wakeEvt); // R9
endmodule

// File: rtl/mdrop_rx_ctrl.sv
module mdrop_rx_ctrl
  import mdrop_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineS,
  input  logic      abort,
  output rxStrobe_t strobe
);
  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int BIT_W    = $clog2(DATA_BITS + 1);
  localparam int MID_CNT  = OVERSAMPLE / 2 - 1;
  localparam int FULL_CNT = OVERSAMPLE - 1;

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             atMid;
  logic             atFull;

  assign atMid  = (tickCnt == CNT_W'(MID_CNT));
  assign atFull = (tickCnt == CNT_W'(FULL_CNT));

  always_comb begin
    strobe = '0;
    if (sampleTick && !abort) begin
      if (state == ST_DATA && atFull) strobe.shiftEn = 1'b1;
      if (state == ST_STOP && atFull) begin
        strobe.frameDone = 1'b1;
        strobe.stopBad   = ~lineS;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (abort) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!lineS) state <= ST_START;
        end
        ST_START: begin
          if (atMid) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= lineS ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (atFull) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == BIT_W'(DATA_BITS - 1)) state <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atFull) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NINE_SHIFTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone |-> (bitCnt == BIT_W'(DATA_BITS))); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftEn, strobe.frameDone})); // R1
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && sampleTick && atMid && lineS && !abort) |=> (state == ST_IDLE)); // R11
endmodule

// File: rtl/mdrop_rx_dp.sv
module mdrop_rx_dp
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineS,
  input  rxStrobe_t            strobe,
  input  logic                 attnSet,
  input  logic                 bufRead,
  input  logic                 statusWr,
  input  logic                 lpEnter,
  output logic [DATA_BITS-2:0] rxData,
  output logic                 rxBit9,
  output logic                 bufFull,
  output logic                 frameErr,
  output logic                 overrunErr,
  output logic                 attnArmed
);
  localparam int MSB = DATA_BITS - 1;

  logic [MSB:0] shiftReg;
  logic         isAddr;
  logic         accept;

  assign isAddr = shiftReg[MSB];
  assign accept = strobe.frameDone & (~attnArmed | isAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      rxData     <= '0;
      rxBit9     <= 1'b0;
      bufFull    <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      attnArmed  <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {lineS, shiftReg[MSB:1]};

      if (accept) begin
        rxData <= shiftReg[MSB-1:0];
        rxBit9 <= isAddr;
      end

      if (lpEnter)       bufFull <= 1'b0;
      else if (accept)   bufFull <= 1'b1;
      else if (bufRead)  bufFull <= 1'b0;

      if (lpEnter)                       overrunErr <= 1'b0;
      else if (accept && bufFull)        overrunErr <= 1'b1;
      else if (statusWr)                 overrunErr <= 1'b0;

      if (lpEnter)                       frameErr <= 1'b0;
      else if (accept && strobe.stopBad) frameErr <= 1'b1;
      else if (statusWr)                 frameErr <= 1'b0;

      if (attnSet)               attnArmed <= 1'b1;
      else if (accept && isAddr) attnArmed <= 1'b0;
    end
  end

  AST_DISCARD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && attnArmed && !isAddr) |=> $stable(rxData)); // R3
  AST_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && isAddr && !lpEnter) |=> (bufFull && rxBit9)); // R2
  AST_ATTN_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && attnArmed && isAddr && !attnSet) |=> !attnArmed); // R4
  AST_LP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    lpEnter |=> !(bufFull || frameErr || overrunErr)); // R10
  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && !strobe.frameDone && !lpEnter) |=> (!frameErr && !overrunErr)); // R7
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxPin,
  input  logic                 txLoopIn,
  input  logic [1:0]           charLenSel,
  input  logic                 wakeEn,
  input  logic                 wakeFallSel,
  input  logic                 lowPower,
  input  logic                 attnSet,
  input  logic                 bufRead,
  input  logic                 statusWr,
  output logic [DATA_BITS-2:0] rxData,
  output logic                 rxBit9,
  output logic                 bufFull,
  output logic                 frameErr,
  output logic                 overrunErr,
  output logic                 attnArmed,
  output logic                 wakeEvt
);
  logic      lineS;
  logic      lpEnter;
  rxStrobe_t strobe;

  mdrop_rx_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk(clk), .rstN(rstN), .rxPin(rxPin), .txLoopIn(txLoopIn),
    .charLenSel(charLenSel), .wakeEn(wakeEn), .wakeFallSel(wakeFallSel),
    .lowPower(lowPower), .lineS(lineS), .wakeEvt(wakeEvt), .lpEnter(lpEnter)
  );

  mdrop_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineS(lineS),
    .abort(lpEnter), .strobe(strobe)
  );

  mdrop_rx_dp #(.DATA_BITS(DATA_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .lineS(lineS), .strobe(strobe),
    .attnSet(attnSet), .bufRead(bufRead), .statusWr(statusWr),
    .lpEnter(lpEnter), .rxData(rxData), .rxBit9(rxBit9), .bufFull(bufFull),
    .frameErr(frameErr), .overrunErr(overrunErr), .attnArmed(attnArmed)
  );
endmodule

// File: tb/mdrop_rx_tb_top.sv
`timescale 1ns/1ps
module mdrop_rx_tb_top;
  localparam int BIT_CLK = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxPin = 1'b1;
  logic       txLoopIn = 1'b1;
  logic [1:0] charLenSel = 2'b00;
  logic       wakeEn = 1'b0;
  logic       wakeFallSel = 1'b1;
  logic       lowPower = 1'b0;
  logic       attnSet = 1'b0;
  logic       bufRead = 1'b0;
  logic       statusWr = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, bufFull, frameErr, overrunErr, attnArmed, wakeEvt;

  int total = 0;
  int bad = 0;
  int wakeCnt = 0;

  mdrop_rx dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxPin(rxPin),
    .txLoopIn(txLoopIn), .charLenSel(charLenSel), .wakeEn(wakeEn),
    .wakeFallSel(wakeFallSel), .lowPower(lowPower), .attnSet(attnSet),
    .bufRead(bufRead), .statusWr(statusWr), .rxData(rxData), .rxBit9(rxBit9),
    .bufFull(bufFull), .frameErr(frameErr), .overrunErr(overrunErr),
    .attnArmed(attnArmed), .wakeEvt(wakeEvt)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) sampleTick <= 1'b0;
    else sampleTick <= ~sampleTick;
    if (wakeEvt) wakeCnt <= wakeCnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLine(input bit viaLoop, input logic v);
    if (viaLoop) txLoopIn = v;
    else rxPin = v;
  endtask

  task automatic sendChar(input bit viaLoop, input logic [8:0] val, input logic stopVal);
    @(negedge clk);
    setLine(viaLoop, 1'b0);
    idle(BIT_CLK);
    for (int i = 0; i < 9; i++) begin
      setLine(viaLoop, val[i]);
      idle(BIT_CLK);
    end
    setLine(viaLoop, stopVal);
    idle(stopVal ? BIT_CLK : 24);
    setLine(viaLoop, 1'b1);
    idle(48);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R2 reset bufFull", bufFull, 0);
    chk("R5 reset frameErr", frameErr, 0);
    chk("R6 reset overrunErr", overrunErr, 0);
    chk("R4 reset attnArmed", attnArmed, 0);
    chk("R9 reset wakeEvt", wakeEvt, 0);
    chk("R1 reset rxData", rxData, 0);
  endtask

  task automatic testBasic();
    sendChar(0, 9'h0A5, 1);
    chk("R1 data byte", rxData, 8'hA5);
    chk("R1 ninth bit 0", rxBit9, 0);
    chk("R2 bufFull set", bufFull, 1);
    chk("R5 no frame error", frameErr, 0);
    pulse(bufRead);
    chk("R2 bufRead clears", bufFull, 0);
    sendChar(0, 9'h13C, 1);
    chk("R1 data byte 2", rxData, 8'h3C);
    chk("R1 ninth bit 1", rxBit9, 1);
  endtask

  task automatic testOverrun();
    sendChar(0, 9'h055, 1);
    chk("R6 overrun set", overrunErr, 1);
    chk("R6 new data overwrites", rxData, 8'h55);
    chk("R6 bufFull still set", bufFull, 1);
    pulse(statusWr);
    chk("R7 overrun cleared", overrunErr, 0);
    chk("R7 data kept", rxData, 8'h55);
    chk("R7 ninth bit kept", rxBit9, 0);
    chk("R7 bufFull kept", bufFull, 1);
    pulse(bufRead);
  endtask

  task automatic testFraming();
    sendChar(0, 9'h0F0, 0);
    chk("R5 frame error set", frameErr, 1);
    chk("R5 data stored", rxData, 8'hF0);
    pulse(statusWr);
    chk("R7 frame error cleared", frameErr, 0);
    pulse(bufRead);
  endtask

  task automatic testAttention();
    pulse(attnSet);
    chk("R4 attention armed", attnArmed, 1);
    sendChar(0, 9'h011, 1);
    chk("R3 data discarded bufFull", bufFull, 0);
    chk("R3 data discarded rxData", rxData, 8'hF0);
    chk("R3 still armed", attnArmed, 1);
    sendChar(0, 9'h066, 0);
    chk("R3 discarded no frame error", frameErr, 0);
    chk("R3 discarded bufFull", bufFull, 0);
    sendChar(0, 9'h1A7, 1);
    chk("R4 address accepted", rxData, 8'hA7);
    chk("R4 address ninth bit", rxBit9, 1);
    chk("R4 address bufFull", bufFull, 1);
    chk("R4 attention disarmed", attnArmed, 0);
    pulse(bufRead);
    sendChar(0, 9'h022, 1);
    chk("R4 data accepted after address", rxData, 8'h22);
    chk("R4 data bufFull", bufFull, 1);
    pulse(bufRead);
    pulse(attnSet);
    sendChar(0, 9'h033, 1);
    chk("R4 re-armed discards", rxData, 8'h22);
    chk("R4 re-armed bufFull", bufFull, 0);
    sendChar(0, 9'h100, 1);
    chk("R4 second address disarms", attnArmed, 0);
    pulse(bufRead);
  endtask

  task automatic testLoopback();
    charLenSel = 2'b11;
    idle(4);
    rxPin = 1'b0;
    sendChar(1, 9'h1C3, 1);
    chk("R8 loopback data", rxData, 8'hC3);
    chk("R8 loopback ninth bit", rxBit9, 1);
    chk("R8 loopback bufFull", bufFull, 1);
    rxPin = 1'b1;
    idle(4);
    charLenSel = 2'b01;
    pulse(bufRead);
    sendChar(1, 9'h05A, 1);
    chk("R8 txLoopIn ignored", bufFull, 0);
    chk("R8 txLoopIn ignored data", rxData, 8'hC3);
    charLenSel = 2'b00;
  endtask

  task automatic testFalseStart();
    @(negedge clk);
    rxPin = 1'b0;
    idle(8);
    rxPin = 1'b1;
    idle(400);
    chk("R11 glitch no character", bufFull, 0);
    chk("R11 glitch data unchanged", rxData, 8'hC3);
  endtask

  task automatic testWake();
    int base;
    wakeEn = 1'b1;
    wakeFallSel = 1'b1;
    idle(4);
    base = wakeCnt;
    rxPin = 1'b0;
    idle(8);
    chk("R9 falling edge wakes", wakeCnt - base, 1);
    rxPin = 1'b1;
    idle(8);
    chk("R9 rising edge ignored", wakeCnt - base, 1);
    idle(400);
    wakeFallSel = 1'b0;
    idle(4);
    base = wakeCnt;
    rxPin = 1'b0;
    idle(8);
    chk("R9 rising mode ignores fall", wakeCnt - base, 0);
    rxPin = 1'b1;
    idle(8);
    chk("R9 rising mode wakes", wakeCnt - base, 1);
    idle(400);
    wakeEn = 1'b0;
    wakeFallSel = 1'b1;
    idle(4);
    base = wakeCnt;
    rxPin = 1'b0;
    idle(8);
    rxPin = 1'b1;
    idle(8);
    chk("R9 disabled no wake", wakeCnt - base, 0);
    idle(400);
  endtask

  task automatic testLowPower();
    sendChar(0, 9'h0AA, 0);
    chk("R10 setup bufFull", bufFull, 1);
    chk("R10 setup frameErr", frameErr, 1);
    sendChar(0, 9'h0BB, 1);
    chk("R10 setup overrun", overrunErr, 1);
    pulse(attnSet);
    @(negedge clk);
    rxPin = 1'b0;
    idle(BIT_CLK * 3);
    lowPower = 1'b1;
    @(negedge clk);
    rxPin = 1'b1;
    @(negedge clk);
    chk("R10 bufFull cleared", bufFull, 0);
    chk("R10 frameErr cleared", frameErr, 0);
    chk("R10 overrun cleared", overrunErr, 0);
    chk("R10 data kept", rxData, 8'hBB);
    chk("R10 attention kept", attnArmed, 1);
    idle(20);
    lowPower = 1'b0;
    idle(400);
    chk("R10 aborted character dropped", bufFull, 0);
    sendChar(0, 9'h101, 1);
    chk("R4 address after low power", rxData, 8'h01);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(4);
    testReset();
    testBasic();
    testOverrun();
    testFraming();
    testAttention();
    testLoopback();
    testFalseStart();
    testWake();
    testLowPower();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule